// File: doc/BRIEF.md
# Windowed integer register file

This block stores the integer registers of a processor whose register set is split into overlapping windows and into several selectable banks of global registers. Every access names an architectural index; two state registers, the active window number and the active global bank, turn that index into a location in one flat physical array. Within a window, the upper eight windowed registers are the same storage as the lower eight windowed registers of the window that follows it. The window space wraps around at its end.

Beyond the ordinary architectural range, the index space also reaches three further groups. The first is a short tail of scratch registers for micro-operations. The second is a copy of the architectural range that reaches the window below the active one. The third is a copy that reaches the window above it. An index past all of these is rejected. The block has two combinational read ports and one write port that commits on the clock edge. A separate command port loads either the window number or the global bank.

Top module: `regwin_file`

## Requirements
- R1: After reset the window number and the global bank are both 0, every physical entry reads as zero, and the error output is low while all indices presented are valid.
- R2: Architectural indices 0 to 7 address global bank G at physical entry G*8 + index, where G is the current global bank. Indices 0 to 7 of both neighbour ranges (offsets 40..47 and 72..79) reach the same entries.
- R3: An index r in 8..31 addresses physical entry 32 + ((r - 8 - W*16 + 128) mod 128), where W is the current window (default 8 windows, 4 global banks). As a result, index r in 24..31 under window W is the same storage as r - 16 under window (W - 1) mod 8.
- R4: Indices 32..39 address the scratch entries 160..167. They do not depend on the window or the global bank.
- R5: Index 40 + k (k in 8..31) addresses the same entry as index k under window (W - 1) mod 8. Window 0 therefore reaches window 7.
- R6: Index 72 + k (k in 8..31) addresses the same entry as index k under window (W + 1) mod 8. Window 7 therefore reaches window 0.
- R7: An index of 104 or more is invalid. A read of it returns zero and raises the error output in that cycle. A write to it is dropped, changes no entry, and raises the error output in that cycle.
- R8: When the command valid is high, code 2'b01 loads the window number from the low 3 value bits, and code 2'b10 loads the global bank from the low 2 value bits. Both take effect from the next cycle; accesses in the same cycle use the old value. Codes 2'b00 and 2'b11 change nothing and raise the error output in that cycle.
- R9: A write lands at the clock edge. A read of the same entry in the same cycle returns the old data, and the new data is visible from the next cycle.
- R10: The two read ports are independent. Each returns the contents of the entry its own index selects, and they agree whenever both indices are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdxA | input | 7 | Read port A architectural index |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdIdxB | input | 7 | Read port B architectural index |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | Write request |
| wrIdx | input | 7 | Write architectural index |
| wrData | input | 32 | Write data |
| ctxValid | input | 1 | Context command valid |
| ctxCmd | input | 2 | Context command code (01 window, 10 global bank) |
| ctxVal | input | 3 | Value loaded by the context command |
| err | output | 1 | Invalid index or illegal command in this cycle |

## Verification
A write and a read of the same physical entry can fall in the same cycle. The bench provokes this both with one index on both ports and with two different indices that alias the same entry. It judges the result by requiring the old data in that cycle and the new data in the next. A context change can also coincide with a write. The bench drives a window load and a write in the same cycle, then checks that the write landed under the old window while later reads decode with the new one.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    CTX_BAD_LO  = 2'b00,
    CTX_SET_WIN = 2'b01,
    CTX_SET_GLB = 2'b10,
    CTX_BAD_HI  = 2'b11
  } ctxCmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrGo;
    logic ldWin;
    logic ldGlb;
  } dpStrobe_t;

  // index validity from datapath to control
  typedef struct packed {
    logic badRdA;
    logic badRdB;
    logic badWr;
  } dpStatus_t;

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int NUM_ARCH  = 32,
  parameter int NUM_MICRO = 8,
  parameter int NUM_WIN   = 8,
  parameter int MAX_GL    = 4,
  parameter int IDX_W     = 7,
  parameter int PHYS_W    = 8,
  parameter int WIN_W     = 3,
  parameter int GL_W      = 2
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [WIN_W-1:0]  win,
  input  logic [GL_W-1:0]   glb,
  output logic [PHYS_W-1:0] phys,
  output logic              valid
);
  localparam int GLB_SPAN   = MAX_GL * 8;
  localparam int WIN_SPAN   = NUM_WIN * 16;
  localparam int MICRO_BASE = GLB_SPAN + WIN_SPAN;
  localparam int PREV_BASE  = NUM_ARCH + NUM_MICRO;
  localparam int NEXT_BASE  = PREV_BASE + NUM_ARCH;
  localparam int IDX_END    = NEXT_BASE + NUM_ARCH;

  int   iv;
  int   loc;
  int   w;
  int   t;
  int   p;
  logic micro;

  always_comb begin
    iv    = int'(idx);
    w     = int'(win);
    loc   = iv;
    micro = 1'b0;
    valid = 1'b1;
    t     = 0;
    p     = 0;
    if (iv < NUM_ARCH) begin
      loc = iv;
    end else if (iv < PREV_BASE) begin
      micro = 1'b1;
    end else if (iv < NEXT_BASE) begin
      loc = iv - PREV_BASE;
      w   = (w == 0) ? NUM_WIN - 1 : w - 1;
    end else if (iv < IDX_END) begin
      loc = iv - NEXT_BASE;
      w   = (w == NUM_WIN - 1) ? 0 : w + 1;
    end else begin
      valid = 1'b0;
    end

    if (!valid) begin
      p = 0;
    end else if (micro) begin
      p = MICRO_BASE + (iv - NUM_ARCH);
    end else if (loc < 8) begin
      p = int'(glb) * 8 + loc;
    end else begin
      // one conditional subtract replaces the modulo
      t = (loc - 8) + (NUM_WIN - w) * 16;
      if (t >= WIN_SPAN) t = t - WIN_SPAN;
      p = GLB_SPAN + t;
    end
    phys = PHYS_W'(p);
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      ctxValid,
  input  logic [1:0] ctxCmd,
  input  dpStatus_t stat,
  output dpStrobe_t stb,
  output logic      err
);
  logic cmdWin;
  logic cmdGlb;
  logic cmdBad;

  assign cmdWin = (ctxCmd == CTX_SET_WIN);
  assign cmdGlb = (ctxCmd == CTX_SET_GLB);
  assign cmdBad = ctxValid & ~(cmdWin | cmdGlb);

  assign stb.wrGo  = wrEn & ~stat.badWr;
  assign stb.ldWin = ctxValid & cmdWin;
  assign stb.ldGlb = ctxValid & cmdGlb;

  assign err = stat.badRdA | stat.badRdB | (wrEn & stat.badWr) | cmdBad;

  AST_ILLEGAL_CMD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ctxValid && (ctxCmd == 2'b00 || ctxCmd == 2'b11) |-> err && !stb.ldWin && !stb.ldGlb); // R8

  AST_BAD_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && stat.badWr |-> err && !stb.wrGo); // R7

endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_ARCH  = 32,
  parameter int NUM_MICRO = 8,
  parameter int NUM_WIN   = 8,
  parameter int MAX_GL    = 4,
  parameter int NUM_PHYS  = 168,
  parameter int IDX_W     = 7,
  parameter int PHYS_W    = 8,
  parameter int WIN_W     = 3,
  parameter int GL_W      = 2,
  parameter int CTX_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CTX_W-1:0]  ctxVal,
  input  dpStrobe_t         stb,
  output dpStatus_t         stat,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int NUM_PORTS = 3;
  localparam int WR_PORT   = 2;

  logic [WIN_W-1:0]  winQ;
  logic [GL_W-1:0]   glbQ;
  logic [DATA_W-1:0] mem [NUM_PHYS];

  logic [IDX_W-1:0]  idxArr   [NUM_PORTS];
  logic [PHYS_W-1:0] physArr  [NUM_PORTS];
  logic              validArr [NUM_PORTS];

  assign idxArr[0]       = rdIdxA;
  assign idxArr[1]       = rdIdxB;
  assign idxArr[WR_PORT] = wrIdx;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gMap
    regwin_map #(
      .NUM_ARCH (NUM_ARCH),
      .NUM_MICRO(NUM_MICRO),
      .NUM_WIN  (NUM_WIN),
      .MAX_GL   (MAX_GL),
      .IDX_W    (IDX_W),
      .PHYS_W   (PHYS_W),
      .WIN_W    (WIN_W),
      .GL_W     (GL_W)
    ) u_map (
      .idx  (idxArr[g]),
      .win  (winQ),
      .glb  (glbQ),
      .phys (physArr[g]),
      .valid(validArr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winQ <= '0;
      glbQ <= '0;
      for (int k = 0; k < NUM_PHYS; k++) mem[k] <= '0;
    end else begin
      if (stb.wrGo)  mem[physArr[WR_PORT]] <= wrData;
      if (stb.ldWin) winQ <= ctxVal[WIN_W-1:0];
      if (stb.ldGlb) glbQ <= ctxVal[GL_W-1:0];
    end
  end

  assign rdDataA = validArr[0] ? mem[physArr[0]] : '0;
  assign rdDataB = validArr[1] ? mem[physArr[1]] : '0;

  assign stat.badRdA = ~validArr[0];
  assign stat.badRdB = ~validArr[1];
  assign stat.badWr  = ~validArr[WR_PORT];

  AST_PHYS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !stat.badWr |-> int'(physArr[WR_PORT]) < NUM_PHYS); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrGo |=> mem[$past(physArr[WR_PORT])] == $past(wrData)); // R9

  AST_PORT_AGREE: assert property (@(posedge clk) disable iff (!rstN)
    rdIdxA == rdIdxB |-> rdDataA == rdDataB); // R10

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_ARCH  = 32,
  parameter int NUM_MICRO = 8,
  parameter int NUM_WIN   = 8,
  parameter int MAX_GL    = 4,
  localparam int NUM_IDX  = 3 * NUM_ARCH + NUM_MICRO,
  localparam int NUM_PHYS = MAX_GL * 8 + NUM_WIN * 16 + NUM_MICRO,
  localparam int IDX_W    = $clog2(NUM_IDX + 1),
  localparam int PHYS_W   = $clog2(NUM_PHYS),
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int GL_W     = $clog2(MAX_GL),
  localparam int CTX_W    = (WIN_W > GL_W) ? WIN_W : GL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ctxValid,
  input  logic [1:0]        ctxCmd,
  input  logic [CTX_W-1:0]  ctxVal,
  output logic              err
);
  dpStrobe_t stb;
  dpStatus_t stat;

  regwin_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .ctxValid(ctxValid),
    .ctxCmd  (ctxCmd),
    .stat    (stat),
    .stb     (stb),
    .err     (err)
  );

  regwin_dp #(
    .DATA_W   (DATA_W),
    .NUM_ARCH (NUM_ARCH),
    .NUM_MICRO(NUM_MICRO),
    .NUM_WIN  (NUM_WIN),
    .MAX_GL   (MAX_GL),
    .NUM_PHYS (NUM_PHYS),
    .IDX_W    (IDX_W),
    .PHYS_W   (PHYS_W),
    .WIN_W    (WIN_W),
    .GL_W     (GL_W),
    .CTX_W    (CTX_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .rdIdxA (rdIdxA),
    .rdIdxB (rdIdxB),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .ctxVal (ctxVal),
    .stb    (stb),
    .stat   (stat),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB)
  );

  AST_CTX_WIN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctxValid && ctxCmd == 2'b01 |=> u_dp.winQ == $past(ctxVal[WIN_W-1:0])); // R8

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctxValid && (ctxCmd == 2'b00 || ctxCmd == 2'b11)
    |=> $stable(u_dp.winQ) && $stable(u_dp.glbQ)); // R8

endmodule

// File: tb/tb_regwin_file.sv
module tb_regwin_file;
  localparam int DW    = 32;
  localparam int NA    = 32;
  localparam int NM    = 8;
  localparam int NW    = 8;
  localparam int NG    = 4;
  localparam int NIDX  = 3 * NA + NM;
  localparam int NPHYS = NG * 8 + NW * 16 + NM;
  localparam int IW    = 7;
  localparam int CW    = 3;
  localparam int NV    = 12;

  // {window, bank, write index, read index, data}
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 2'd0, 7'd3,  7'd3,  32'hA000_0003},
    {3'd0, 2'd2, 7'd3,  7'd3,  32'hA200_0003},
    {3'd2, 2'd1, 7'd9,  7'd9,  32'hB000_0009},
    {3'd2, 2'd1, 7'd24, 7'd48, 32'hB100_0024},
    {3'd3, 2'd0, 7'd27, 7'd51, 32'hB200_0027},
    {3'd7, 2'd0, 7'd96, 7'd8,  32'hC000_0096},
    {3'd0, 2'd3, 7'd48, 7'd24, 32'hC100_0048},
    {3'd5, 2'd2, 7'd35, 7'd35, 32'hD000_0035},
    {3'd1, 2'd1, 7'd33, 7'd33, 32'hD100_0033},
    {3'd6, 2'd3, 7'd5,  7'd45, 32'hE000_0005},
    {3'd4, 2'd2, 7'd77, 7'd5,  32'hE100_0077},
    {3'd1, 2'd0, 7'd31, 7'd55, 32'hF000_0031}
  };

  logic          clk;
  logic          rstN;
  logic [IW-1:0] rdIdxA, rdIdxB, wrIdx;
  logic [DW-1:0] rdDataA, rdDataB, wrData;
  logic          wrEn, ctxValid, err;
  logic [1:0]    ctxCmd;
  logic [CW-1:0] ctxVal;

  int vecs = 0;
  int miss = 0;
  int cwpM = 0;
  int glM  = 0;
  logic [DW-1:0] shadow [NPHYS];

  regwin_file #(.DATA_W(DW), .NUM_ARCH(NA), .NUM_MICRO(NM), .NUM_WIN(NW), .MAX_GL(NG)) dut (
    .clk(clk), .rstN(rstN),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .ctxValid(ctxValid), .ctxCmd(ctxCmd), .ctxVal(ctxVal),
    .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int physOf(int i, int c, int g);
    int loc;
    int w;
    if (i < 0 || i >= NIDX) return -1;
    if (i >= NA && i < NA + NM) return NG * 8 + NW * 16 + (i - NA);
    if (i < NA) begin
      loc = i; w = c;
    end else if (i < 2 * NA + NM) begin
      loc = i - (NA + NM); w = (c - 1 + NW) % NW;
    end else begin
      loc = i - (2 * NA + NM); w = (c + 1) % NW;
    end
    if (loc < 8) return g * 8 + loc;
    return NG * 8 + ((loc - 8 - w * 16 + NW * 16) % (NW * 16));
  endfunction

  function automatic logic [DW-1:0] expRead(int i);
    int p;
    p = physOf(i, cwpM, glM);
    if (p < 0) return '0;
    return shadow[p];
  endfunction

  function automatic string regionTag(int i);
    if (i < 8)           return "R2";
    if (i < NA)          return "R3";
    if (i < NA + NM)     return "R4";
    if (i < 2 * NA + NM) return "R5";
    if (i < NIDX)        return "R6";
    return "R7";
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit we, int wi, logic [DW-1:0] wd, int ra, int rb,
                      bit cv, logic [1:0] cc, int cvv, string tagA, string tagB);
    bit expErr;
    bit badCmd;
    @(negedge clk);
    wrEn = we; wrIdx = IW'(wi); wrData = wd;
    rdIdxA = IW'(ra); rdIdxB = IW'(rb);
    ctxValid = cv; ctxCmd = cc; ctxVal = CW'(cvv);
    #1;
    chk(tagA, "rdDataA", rdDataA, expRead(ra));
    chk(tagB, "rdDataB", rdDataB, expRead(rb));
    badCmd = cv && (cc == 2'b00 || cc == 2'b11);
    expErr = (physOf(ra, cwpM, glM) < 0) || (physOf(rb, cwpM, glM) < 0) ||
             (we && physOf(wi, cwpM, glM) < 0) || badCmd;
    chk(badCmd ? "R8" : "R7", "err", {31'd0, err}, {31'd0, expErr});
    @(posedge clk);
    if (we && physOf(wi, cwpM, glM) >= 0) shadow[physOf(wi, cwpM, glM)] = wd;
    if (cv && cc == 2'b01) cwpM = cvv % NW;
    if (cv && cc == 2'b10) glM = cvv % NG;
  endtask

  initial begin
    #100000;
    miss++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPHYS; k++) shadow[k] = '0;
    rstN = 1'b0; wrEn = 1'b0; wrIdx = '0; wrData = '0;
    rdIdxA = '0; rdIdxB = '0; ctxValid = 1'b0; ctxCmd = 2'b00; ctxVal = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, entries zero, no error
    step(0, 0, '0, 0, NIDX - 1, 0, 2'b00, 0, "R1", "R1");
    step(0, 0, '0, 20, 36, 0, 2'b00, 0, "R1", "R1");

    // table of windowed, global, scratch and alias accesses
    for (int v = 0; v < NV; v++) begin
      int c  = int'(VEC[v][50:48]);
      int g  = int'(VEC[v][47:46]);
      int wi = int'(VEC[v][45:39]);
      int ri = int'(VEC[v][38:32]);
      logic [DW-1:0] d = VEC[v][31:0];
      step(0, 0, '0, 0, 0, 1, 2'b01, c, "R8", "R8");
      step(0, 0, '0, 0, 0, 1, 2'b10, g, "R8", "R8");
      step(1, wi, d, ri, wi, 0, 2'b00, 0, regionTag(ri), "R9");
      step(0, 0, '0, ri, wi, 0, 2'b00, 0, regionTag(ri), regionTag(wi));
    end

    // R9: same-cycle write and read of one entry, direct and aliased
    step(1, 10, 32'h1234_0010, 10, 10, 0, 2'b00, 0, "R9", "R9");
    step(0, 0, '0, 10, 10, 0, 2'b00, 0, "R9", "R9");
    step(1, 26, 32'h1234_0026, 50, 26, 0, 2'b00, 0, "R9", "R9");
    step(0, 0, '0, 50, 26, 0, 2'b00, 0, "R9", "R9");

    // R8: window load together with a write uses the old window
    step(1, 12, 32'h5555_0012, 12, 28, 1, 2'b01, 5, "R8", "R8");
    step(0, 0, '0, 12, 28, 0, 2'b00, 0, "R8", "R8");
    step(0, 0, '0, 12 + 40, 28 + 72, 0, 2'b00, 0, "R8", "R8");

    // R8: illegal codes leave both state registers alone
    step(0, 0, '0, 12, 3, 1, 2'b00, 2, "R8", "R8");
    step(0, 0, '0, 12, 3, 1, 2'b11, 6, "R8", "R8");
    step(0, 0, '0, 12, 3, 0, 2'b00, 0, "R8", "R8");

    // R7: invalid writes dropped, invalid reads zero
    step(1, 104, 32'hBAD0_0104, 0, 120, 0, 2'b00, 0, "R7", "R7");
    step(1, 127, 32'hBAD0_0127, 127, 104, 0, 2'b00, 0, "R7", "R7");
    for (int i = 0; i < NIDX; i++) begin
      step(0, 0, '0, i, NIDX - 1 - i, 0, 2'b00, 0, "R7", "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule